// File: doc/BRIEF.md
# Shared Timebase Counter with Sticky Event Flags

This block holds a 16-bit counter that serves as the common time reference for five compare/capture channels. The counter advances by one on every cycle in which the selected count-source pulse is high and the run bit is set. A single 8-bit status byte packs the run bit, an overflow flag, one reserved bit and five per-channel event flags. Hardware raises the flags, and only a software write lowers them. One interrupt request is formed from the flags and their enable inputs.

Software reaches the block through a small register bus with a write strobe, a 2-bit address, write data, and combinational read data. Address 0 selects the status byte. Addresses 1 and 2 select the low and high byte of the counter, and those bytes can be loaded only while the counter is stopped. Each channel reports an event by pulsing its bit of `ch_evt` for one cycle. The channel interrupt enables and the overflow interrupt enable come from registers outside this block.

Top module: `shared_timebase`

## Requirements
- R1: While `rst` is high at a clock edge, the counter, the run bit, the overflow flag and all event flags clear to 0. The status byte then reads 0x00 and `irq` is 0.
- R2: With the run bit at 1, `count` rises by one on each clock edge at which `cnt_tick` is 1. With the run bit at 0 or `cnt_tick` at 0, `count` holds, except for the byte loads of R9.
- R3: When the counter steps from 0xFFFF, it becomes 0x0000, and the overflow flag (status bit 7) is 1 in the following cycle.
- R4: A status write with bit 7 set to 1 sets the overflow flag, and a status write with bit 7 at 0 clears it. If a rollover happens in the same cycle as a clearing write, the flag ends at 1.
- R5: Status bit 6 is the run bit. A status write loads it from write-data bit 6, and it reads back at bit 6.
- R6: A pulse on `ch_evt[n]` sets status bit n (n = 0..4). The bit stays at 1 until a status write carries 0 in bit n, and writing 1 to it leaves it unchanged. A pulse in the same cycle as a clearing write leaves the bit at 1.
- R7: Status bit 5 is reserved. It always reads 0 in this implementation, and writes to it have no effect.
- R8: `irq` equals (overflow flag AND `ovf_ie`) OR, for any n, (event flag n AND `ch_ie[n]`). It follows the flags and enables in the same cycle.
- R9: A bus write to address 1 loads the counter's low byte, and a write to address 2 loads its high byte, but only while the run bit is 0. While the counter runs, these writes are ignored. Reads of addresses 1 and 2 return the current counter bytes, address 3 reads 0, and writes to address 3 do nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 status, 1 counter low, 2 counter high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| cnt_tick | input | 1 | Count-source pulse from the clock-source selector |
| ch_evt | input | 5 | Per-channel event set pulses |
| ch_ie | input | 5 | Per-channel interrupt enables |
| ovf_ie | input | 1 | Overflow interrupt enable |
| count | output | 16 | Current timebase value for the channels |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check the following on every cycle: the one-step advance and the hold of the counter, the rollover into zero with the overflow flag raised, the persistence of set flags between clearing writes, the zero reserved read, and a quiet `irq` when every enable is low. Some behaviours need a known history and deliberate collisions, so only the bench scenarios show them. These are the priority of a rollover over a clearing write in the same cycle, an event pulse arriving together with a clear, the rejection of counter loads while running, and the exact interrupt value under mixed enables. The random phase checks every read port and `irq` against a bench model over thousands of cycles.

// File: rtl/stb_pkg.sv
package stb_pkg;

    localparam int DW         = 8;
    localparam int NCH        = 5;
    localparam int CNT_W_DEF  = 16;
    localparam int ADDR_W_DEF = 2;

    // status byte bit positions (software decodes these)
    localparam int OVF_POS = 7;
    localparam int RUN_POS = 6;
    localparam int RSV_POS = 5;

    // bus address map
    localparam int SEL_STATUS = 0;
    localparam int SEL_CNT0   = 1;

    typedef struct packed {
        logic           ovf;
        logic           run;
        logic           rsv;
        logic [NCH-1:0] ev;
    } status_t;

    typedef struct packed {
        logic          wr;
        logic [DW-1:0] data;
    } stat_cmd_t;

    function automatic logic [DW-1:0] pack_status(input logic ovf,
                                                  input logic run,
                                                  input logic [NCH-1:0] ev);
        status_t s;
        s.ovf = ovf;
        s.run = run;
        s.rsv = 1'b0;
        s.ev  = ev;
        return s;
    endfunction

endpackage

// File: rtl/stb_counter.sv
module stb_counter
    import stb_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               tick,
    input  logic [CNT_W/DW-1:0] byte_wr,
    input  logic [DW-1:0]      wdata,
    output logic [CNT_W-1:0]   count,
    output logic               wrap
);
    localparam int NB = CNT_W / DW;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_n;

    always_comb begin
        cnt_n = cnt_q;
        if (run) begin
            if (tick) cnt_n = cnt_q + 1'b1;
        end else begin
            for (int b = 0; b < NB; b++) begin
                if (byte_wr[b]) cnt_n[b*DW +: DW] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_n;
    end

    assign count = cnt_q;
    assign wrap  = run & tick & (&cnt_q);

endmodule

// File: rtl/stb_flags.sv
module stb_flags
    import stb_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  stat_cmd_t      cmd,
    input  logic           ovf_hw,
    input  logic [NCH-1:0] ch_evt,
    output logic           ovf_q,
    output logic           run_q,
    output logic [NCH-1:0] ev_q
);
    logic           ovf_n;
    logic           run_n;
    logic [NCH-1:0] ev_n;

    // hardware set dominates any software value written in the same cycle
    assign ovf_n = ovf_hw | (cmd.wr ? cmd.data[OVF_POS] : ovf_q);
    assign run_n = cmd.wr ? cmd.data[RUN_POS] : run_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ev
        logic sw_clr;
        assign sw_clr  = cmd.wr & ~cmd.data[i];
        assign ev_n[i] = ch_evt[i] | (ev_q[i] & ~sw_clr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
            run_q <= 1'b0;
            ev_q  <= '0;
        end else begin
            ovf_q <= ovf_n;
            run_q <= run_n;
            ev_q  <= ev_n;
        end
    end

endmodule

// File: rtl/stb_regbus.sv
module stb_regbus
    import stb_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    input  logic [DW-1:0]       status,
    input  logic [CNT_W-1:0]    count,
    output stat_cmd_t           cmd,
    output logic [CNT_W/DW-1:0] byte_wr,
    output logic [DW-1:0]       rdata
);
    localparam int NB = CNT_W / DW;

    logic sel_stat;
    assign sel_stat = (bus_addr == ADDR_W'(SEL_STATUS));

    assign cmd.wr   = bus_wr & sel_stat;
    assign cmd.data = bus_wdata;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign byte_wr[b] = bus_wr & (bus_addr == ADDR_W'(SEL_CNT0 + b));
    end

    always_comb begin
        rdata = '0;
        if (sel_stat) rdata = status;
        for (int b = 0; b < NB; b++) begin
            if (bus_addr == ADDR_W'(SEL_CNT0 + b)) rdata = count[b*DW +: DW];
        end
    end

endmodule

// File: rtl/stb_irq.sv
module stb_irq
    import stb_pkg::*;
(
    input  logic           ovf_q,
    input  logic           ovf_ie,
    input  logic [NCH-1:0] ev_q,
    input  logic [NCH-1:0] ch_ie,
    output logic           irq
);
    logic [NCH:0] src;

    assign src[NCH] = ovf_q & ovf_ie;
    for (genvar i = 0; i < NCH; i++) begin : g_src
        assign src[i] = ev_q[i] & ch_ie[i];
    end

    assign irq = |src;

endmodule

// File: rtl/shared_timebase.sv
module shared_timebase
    import stb_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              cnt_tick,
    input  logic [NCH-1:0]    ch_evt,
    input  logic [NCH-1:0]    ch_ie,
    input  logic              ovf_ie,
    output logic [CNT_W-1:0]  count,
    output logic              irq
);
    localparam int NB = CNT_W / DW;

    stat_cmd_t      cmd;
    logic [NB-1:0]  byte_wr;
    logic           wrap;
    logic           ovf_q;
    logic           run_q;
    logic [NCH-1:0] ev_q;
    logic [DW-1:0]  status;

    assign status = pack_status(ovf_q, run_q, ev_q);

    stb_regbus #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_bus (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .status    (status),
        .count     (count),
        .cmd       (cmd),
        .byte_wr   (byte_wr),
        .rdata     (bus_rdata)
    );

    stb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (run_q),
        .tick    (cnt_tick),
        .byte_wr (byte_wr),
        .wdata   (bus_wdata),
        .count   (count),
        .wrap    (wrap)
    );

    stb_flags u_flags (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .ovf_hw (wrap),
        .ch_evt (ch_evt),
        .ovf_q  (ovf_q),
        .run_q  (run_q),
        .ev_q   (ev_q)
    );

    stb_irq u_irq (
        .ovf_q  (ovf_q),
        .ovf_ie (ovf_ie),
        .ev_q   (ev_q),
        .ch_ie  (ch_ie),
        .irq    (irq)
    );

endmodule

// File: rtl/stb_checker.sv
module stb_checker
    import stb_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     bus_rdata,
    input logic              cnt_tick,
    input logic [NCH-1:0]    ch_evt,
    input logic [NCH-1:0]    ch_ie,
    input logic              ovf_ie,
    input logic [CNT_W-1:0]  count,
    input logic              irq,
    input logic              run_q,
    input logic              ovf_q,
    input logic [NCH-1:0]    ev_q
);
    localparam int NB = CNT_W / DW;

    logic           stat_wr;
    logic           load_any;
    logic           at_top;
    logic [NCH-1:0] keep;

    assign stat_wr  = bus_wr && (bus_addr == ADDR_W'(SEL_STATUS));
    assign load_any = bus_wr && (int'(bus_addr) >= SEL_CNT0) && (int'(bus_addr) < SEL_CNT0 + NB);
    assign at_top   = &count;
    assign keep     = stat_wr ? bus_wdata[NCH-1:0] : {NCH{1'b1}};

    a_r1_reset: assert property (@(posedge clk)
        rst |=> (count == '0 && !ovf_q && !run_q && ev_q == '0));

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (run_q && cnt_tick && !at_top) |=> (count == $past(count) + 1'b1));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!(run_q && cnt_tick) && !load_any) |=> $stable(count));

    a_r9_locked: assert property (@(posedge clk) disable iff (rst)
        (run_q && !cnt_tick) |=> $stable(count));

    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (run_q && cnt_tick && at_top) |=> (count == '0 && ovf_q));

    a_r4_keep: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !stat_wr) |=> ovf_q);

    a_r6_set: assert property (@(posedge clk) disable iff (rst)
        (|ch_evt) |=> ((ev_q & $past(ch_evt)) == $past(ch_evt)));

    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (|ev_q) |=> ((ev_q & $past(ev_q & keep)) == $past(ev_q & keep)));

    a_r7_rsv: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(SEL_STATUS)) |-> !bus_rdata[RSV_POS]);

    a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
        (!ovf_ie && ch_ie == '0) |-> !irq);

endmodule

bind shared_timebase stb_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt_tick  (cnt_tick),
    .ch_evt    (ch_evt),
    .ch_ie     (ch_ie),
    .ovf_ie    (ovf_ie),
    .count     (count),
    .irq       (irq),
    .run_q     (run_q),
    .ovf_q     (ovf_q),
    .ev_q      (ev_q)
);

// File: tb/shared_timebase_tb.sv
`timescale 1ns/1ps
module shared_timebase_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [1:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        cnt_tick;
    logic [4:0]  ch_evt;
    logic [4:0]  ch_ie;
    logic        ovf_ie;
    logic [15:0] count;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model state
    logic [15:0] m_cnt;
    logic        m_ovf, m_run;
    logic [4:0]  m_ev;

    always #5 clk = ~clk;

    shared_timebase u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_tick(cnt_tick),
        .ch_evt(ch_evt), .ch_ie(ch_ie), .ovf_ie(ovf_ie),
        .count(count), .irq(irq)
    );

    function automatic logic [7:0] exp_rdata(input logic [1:0] a);
        case (a)
            2'd0:    return {m_ovf, m_run, 1'b0, m_ev};
            2'd1:    return m_cnt[7:0];
            2'd2:    return m_cnt[15:8];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_irq();
        return (m_ovf & ovf_ie) | (|(m_ev & ch_ie));
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_step(input logic wr, input logic [1:0] a, input logic [7:0] d,
                              input logic tk, input logic [4:0] ev);
        logic        swr;
        logic        wrp;
        logic [15:0] nc;
        swr = wr && (a == 2'd0);
        wrp = m_run && tk && (m_cnt == 16'hFFFF);
        nc  = m_cnt;
        if (m_run) begin
            if (tk) nc = m_cnt + 16'd1;
        end else begin
            if (wr && a == 2'd1) nc[7:0]  = d;
            if (wr && a == 2'd2) nc[15:8] = d;
        end
        m_ovf = wrp | (swr ? d[7] : m_ovf);
        m_run = swr ? d[6] : m_run;
        m_ev  = ev | (swr ? (m_ev & d[4:0]) : m_ev);
        m_cnt = nc;
    endtask

    // one bus cycle: drive at falling edge, check settled outputs, advance model
    task automatic cyc(input logic wr, input logic [1:0] a, input logic [7:0] d,
                       input logic tk, input logic [4:0] ev, input string tag);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; cnt_tick = tk; ch_evt = ev;
        #1;
        check(tag, {8'h00, bus_rdata}, {8'h00, exp_rdata(a)});
        check("R2 count value", count, m_cnt);
        check("R8 irq", {15'd0, irq}, {15'd0, exp_irq()});
        model_step(wr, a, d, tk, ev);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        cnt_tick = 0; ch_evt = 0; ch_ie = 0; ovf_ie = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cnt = 0; m_ovf = 0; m_run = 0; m_ev = 0;
        #1;
        check("R1 reset status", {8'h00, bus_rdata}, 16'h0000);
        check("R1 reset count", count, 16'h0000);
        check("R1 reset irq", {15'd0, irq}, 16'h0000);

        // R9 loads while stopped, R2 hold while stopped
        cyc(1, 2'd1, 8'hFE, 1, 0, "R9 load low");
        cyc(1, 2'd2, 8'hFF, 1, 0, "R9 load high");
        cyc(0, 2'd1, 8'h00, 1, 0, "R9 read low");
        cyc(0, 2'd2, 8'h00, 1, 0, "R9 read high");
        // R5 run, R3 rollover
        cyc(1, 2'd0, 8'h40, 0, 0, "R5 set run");
        cyc(0, 2'd0, 8'h00, 1, 0, "R5 run reads back");
        cyc(0, 2'd0, 8'h00, 1, 0, "R3 at top");
        cyc(0, 2'd0, 8'h00, 0, 0, "R3 overflow flag");
        check("R3 wrapped to zero", count, 16'h0000);
        // R9 ignored while running
        cyc(1, 2'd1, 8'h55, 0, 0, "R9 write while running");
        cyc(0, 2'd1, 8'h00, 0, 0, "R9 running write ignored");
        // R4 software clear and set
        cyc(1, 2'd0, 8'h40, 0, 0, "R4 clear overflow");
        cyc(0, 2'd0, 8'h00, 0, 0, "R4 overflow cleared");
        cyc(1, 2'd0, 8'h80, 0, 0, "R4 software set");
        cyc(0, 2'd0, 8'h00, 0, 0, "R4 software set reads");
        check("R4 software set flag", {15'd0, bus_rdata[7]}, 16'h0001);
        // R4 rollover beats clearing write
        cyc(1, 2'd1, 8'hFF, 0, 0, "R9 load low stopped");
        cyc(1, 2'd2, 8'hFF, 0, 0, "R9 load high stopped");
        cyc(1, 2'd0, 8'hC0, 0, 0, "R5 run keep ovf");
        cyc(1, 2'd0, 8'h40, 1, 0, "R4 clear with wrap");
        cyc(0, 2'd0, 8'h00, 0, 0, "R4 wrap wins over clear");
        check("R4 wrap wins flag", {15'd0, bus_rdata[7]}, 16'h0001);
        // R6 event flags, R7 reserved
        cyc(0, 2'd0, 8'h00, 0, 5'b00101, "R6 event pulse");
        cyc(0, 2'd0, 8'h00, 0, 0, "R6 flags set");
        cyc(1, 2'd0, 8'hFF, 0, 0, "R7 write ones");
        cyc(0, 2'd0, 8'h00, 0, 0, "R7 reserved reads zero");
        check("R7 reserved bit", {15'd0, bus_rdata[5]}, 16'h0000);
        cyc(1, 2'd0, 8'hC4, 0, 0, "R6 clear bit0");
        cyc(0, 2'd0, 8'h00, 0, 0, "R6 bit0 cleared");
        cyc(1, 2'd0, 8'hC0, 0, 5'b00100, "R6 set with clear");
        cyc(0, 2'd0, 8'h00, 0, 0, "R6 set beats clear");
        check("R6 set beats clear bit", {15'd0, bus_rdata[2]}, 16'h0001);
        // R8 enables
        ch_ie = 5'b00100; ovf_ie = 0;
        cyc(0, 2'd0, 8'h00, 0, 0, "R8 channel enable");
        ch_ie = 5'b11011;
        cyc(0, 2'd0, 8'h00, 0, 0, "R8 other enables");
        ch_ie = 5'b00000; ovf_ie = 1;
        cyc(0, 2'd0, 8'h00, 0, 0, "R8 overflow enable");
        cyc(0, 2'd3, 8'h00, 0, 0, "R9 unused address");

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            logic       wr;
            logic [1:0] a;
            logic [7:0] d;
            logic       tk;
            logic [4:0] ev;
            if (i % 50 == 0) begin
                ch_ie  = 5'($urandom);
                ovf_ie = 1'($urandom);
            end
            wr = ($urandom % 8) == 0;
            a  = 2'($urandom);
            d  = 8'($urandom);
            if (a != 2'd0 && ($urandom % 2) == 0) d = 8'hFF;
            tk = ($urandom % 4) != 0;
            ev = (($urandom % 16) == 0) ? 5'($urandom) : 5'd0;
            cyc(wr, a, d, tk, ev, "R4,R6,R9 random read");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule